// File: doc/BRIEF.md
# Tiled Surface Address Calculator

This block turns the description of a block-tiled surface, together with a pixel position inside it, into the words a copy or blit engine needs: the starting byte address, the row pitch measured in tile rows, a partial-tile row word and a high configuration word. Tiles are organised on three levels: a tile is some bytes wide, some rows tall and some slices deep. A 12-bit mode word gives the size of each level as a shift amount. The remaining inputs are the surface width and height, the x, y and z position, the bytes per pixel and a 40-bit base address made of a 32-bit low part and an 8-bit high part.

A caller drives the inputs and pulses `start` while the block is idle. The block copies every input on the accepting edge, so the caller may change them straight away. It then works through the arithmetic in several register stages, using only shifts, masks, adds and multiplies. When the results are ready it raises `done` for one cycle. The results stay on the output registers until the next calculation completes. Linear surfaces do not come through this block.

Top module: `tiled_addr_calc`

## Requirements
- R1: While `rstN` is low, and after it is released, `busy` and `done` are 0 and `addrLow`, `cfgHigh`, `pitchWord`, `yTileWord` and `wideTile` are all 0 until the first result.
- R2: The mode word is decoded as follows. Td = bits 11:8. Th = bits 7:4 + TH_BIAS (default 2). If bits 3:0 equal 0xE, then Tp = 4 and `wideTile` = 0. For any other value of bits 3:0, Tp = 6 and `wideTile` = 1.
- R3: `addrLow` = baseLow + inTile + tileOff, modulo 2^32. Here nTx = ceil(width*bpp / 2^Tp) and nTy = ceil(height / 2^Th). Txo and Tx are the low Tp bits of x*bpp and the value shifted right by Tp. Tyo/Ty and Tzo/Tz are formed the same way from y with Th and from z with Td. inTile = (Tzo<<(Tp+Th)) + (Tyo<<Tp) + Txo, and tileOff = (Tz*nTy*nTx + Ty*nTx + Tx) << (Tp+Th+Td). All intermediate values are 32 bits wide.
- R4: The carry out of the 32-bit sum in R3 is added to baseHigh modulo 2^8. The result appears in `cfgHigh` bits 23:16.
- R5: `cfgHigh` = (addressHigh << 16) | (((1<<Th) >> 2) << Td), taken as 32 bits.
- R6: `pitchWord` = (nTx - 1) << (Tp+Th+Td), taken as 32 bits.
- R7: `yTileWord` = ((1<<Th) << 12) | ((1<<Th) - Tyo), taken as 32 bits.
- R8: A `start` sampled high while idle is accepted. `busy` is 1 from the accepting edge until the edge that raises `done`. `done` rises on the sixth edge after the accepting edge and stays high for exactly one cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored and produces no extra `done`. Input changes after the accepting edge do not affect the result.
- R10: The five result outputs keep their values in every cycle except the one in which `done` rises.
- R11: A `start` that is high in the same cycle as `done` is accepted, and its result follows six edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| modeWord | input | 12 | Tile shape: z shift, y shift code, x tile kind |
| surfWidth | input | 19 | Surface width in pixels |
| surfHeight | input | 13 | Surface height in rows |
| xOff | input | 19 | Pixel x position |
| yOff | input | 13 | Row y position |
| zOff | input | 12 | Slice z position |
| bytesPerPixel | input | 5 | Bytes per pixel |
| baseLow | input | 32 | Low 32 bits of the base address |
| baseHigh | input | 8 | High 8 bits of the base address |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| addrLow | output | 32 | Low 32 bits of the start address |
| cfgHigh | output | 32 | High address and y/z tile size word |
| pitchWord | output | 32 | Pitch in tile-row units |
| yTileWord | output | 32 | Tile height and rows left in the first tile |
| wideTile | output | 1 | The 64-byte-wide tile kind was selected |

## Verification
Two events can happen in the same cycle: the result-ready pulse of one calculation and the acceptance of the next `start`. The bench raises `start` with new inputs in exactly the cycle in which `done` is seen. It then checks three things. The first result must stay on the outputs while the second calculation runs. The second `done` must arrive six edges after its accepting edge. The second result must match a reference model computed from the new inputs. A related case also holds `start` while `busy` is 1, and the bench confirms that this start neither changes the result nor adds a pulse.

// File: rtl/tsac_pkg.sv
package tsac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_SPLIT = 3'd2,
    ST_MUL   = 3'd3,
    ST_MUL2  = 3'd4,
    ST_SUM   = 3'd5,
    ST_FINAL = 3'd6
  } tsac_state_e;

  // strobes from control to datapath, one per stage
  typedef struct packed {
    logic latchIn;
    logic doShift;
    logic doSplit;
    logic doMul;
    logic doMul2;
    logic doSum;
    logic doFinal;
  } tsac_strobe_t;

  localparam int unsigned STAGE_COUNT = 6;

endpackage

// File: rtl/tsac_ctrl.sv
module tsac_ctrl
  import tsac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output tsac_strobe_t strobe,
  output logic         busy,
  output logic         done
);

  tsac_state_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (start) stateNext = ST_SHIFT;
      ST_SHIFT: stateNext = ST_SPLIT;
      ST_SPLIT: stateNext = ST_MUL;
      ST_MUL:   stateNext = ST_MUL2;
      ST_MUL2:  stateNext = ST_SUM;
      ST_SUM:   stateNext = ST_FINAL;
      ST_FINAL: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.latchIn = (stateQ == ST_IDLE) && start;
    strobe.doShift = (stateQ == ST_SHIFT);
    strobe.doSplit = (stateQ == ST_SPLIT);
    strobe.doMul   = (stateQ == ST_MUL);
    strobe.doMul2  = (stateQ == ST_MUL2);
    strobe.doSum   = (stateQ == ST_SUM);
    strobe.doFinal = (stateQ == ST_FINAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      done   <= (stateQ == ST_FINAL);
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/tsac_datapath.sv
module tsac_datapath
  import tsac_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned HIGH_W  = 8,
  parameter int unsigned MODE_W  = 12,
  parameter int unsigned X_W     = 19,
  parameter int unsigned Y_W     = 13,
  parameter int unsigned Z_W     = 12,
  parameter int unsigned BPP_W   = 5,
  parameter int unsigned TH_BIAS = 2,
  parameter int unsigned HIGH_POS = 16,
  parameter int unsigned YT_POS   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  tsac_strobe_t       strobe,
  input  logic [MODE_W-1:0]  modeWord,
  input  logic [X_W-1:0]     surfWidth,
  input  logic [Y_W-1:0]     surfHeight,
  input  logic [X_W-1:0]     xOff,
  input  logic [Y_W-1:0]     yOff,
  input  logic [Z_W-1:0]     zOff,
  input  logic [BPP_W-1:0]   bytesPerPixel,
  input  logic [WORD_W-1:0]  baseLow,
  input  logic [HIGH_W-1:0]  baseHigh,
  output logic [WORD_W-1:0]  addrLow,
  output logic [WORD_W-1:0]  cfgHigh,
  output logic [WORD_W-1:0]  pitchWord,
  output logic [WORD_W-1:0]  yTileWord,
  output logic               wideTile
);

  localparam int unsigned SH_W = 6;
  localparam logic [3:0]  NARROW_CODE = 4'hE;
  localparam logic [SH_W-1:0] TP_NARROW = SH_W'(4);
  localparam logic [SH_W-1:0] TP_WIDE   = SH_W'(6);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  // latched inputs
  logic [MODE_W-1:0] modeQ;
  logic [X_W-1:0]    widthQ, xQ;
  logic [Y_W-1:0]    heightQ, yQ;
  logic [Z_W-1:0]    zQ;
  logic [BPP_W-1:0]  bppQ;
  logic [WORD_W-1:0] baseLowQ;
  logic [HIGH_W-1:0] baseHighQ;

  // stage registers
  logic [SH_W-1:0]   tpQ, thQ, tdQ, tsQ;
  logic              wideQ;
  logic [WORD_W-1:0] xBytesQ, wBytesQ;
  logic [WORD_W-1:0] nTxQ, nTyQ, txQ, txoQ, tyQ, tyoQ, tzQ, tzoQ, yTileQ;
  logic [WORD_W-1:0] rowQ, sliceQ, inTileQ, sliceFullQ, tileIdxQ;

  // combinational helpers
  logic [WORD_W-1:0] tpMask, thMask, tdMask, thSize;
  logic [WORD_W-1:0] offSum, yzSize;
  logic [WORD_W:0]   lowSum;
  logic [HIGH_W-1:0] highNext;

  assign tpMask = (ONE << tpQ) - ONE;
  assign thSize = ONE << thQ;
  assign thMask = thSize - ONE;
  assign tdMask = (ONE << tdQ) - ONE;

  assign offSum   = (tileIdxQ << tsQ) + inTileQ;
  assign lowSum   = {1'b0, baseLowQ} + {1'b0, offSum};
  assign highNext = baseHighQ + HIGH_W'(lowSum[WORD_W]);
  assign yzSize   = (thSize >> 2) << tdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0; widthQ <= '0; xQ <= '0; heightQ <= '0; yQ <= '0;
      zQ <= '0; bppQ <= '0; baseLowQ <= '0; baseHighQ <= '0;
    end else if (strobe.latchIn) begin
      modeQ     <= modeWord;
      widthQ    <= surfWidth;
      heightQ   <= surfHeight;
      xQ        <= xOff;
      yQ        <= yOff;
      zQ        <= zOff;
      bppQ      <= bytesPerPixel;
      baseLowQ  <= baseLow;
      baseHighQ <= baseHigh;
    end
  end

  // stage 1: mode decode and byte-scaled x and width
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tpQ <= '0; thQ <= '0; tdQ <= '0; wideQ <= 1'b0;
      xBytesQ <= '0; wBytesQ <= '0;
    end else if (strobe.doShift) begin
      if (modeQ[3:0] == NARROW_CODE) begin
        tpQ   <= TP_NARROW;
        wideQ <= 1'b0;
      end else begin
        tpQ   <= TP_WIDE;
        wideQ <= 1'b1;
      end
      thQ     <= SH_W'(modeQ[7:4]) + SH_W'(TH_BIAS);
      tdQ     <= SH_W'(modeQ[11:8]);
      xBytesQ <= WORD_W'(xQ) * WORD_W'(bppQ);
      wBytesQ <= WORD_W'(widthQ) * WORD_W'(bppQ);
    end
  end

  // stage 2: split positions into tile index and in-tile part
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nTxQ <= '0; nTyQ <= '0; txQ <= '0; txoQ <= '0; tyQ <= '0;
      tyoQ <= '0; tzQ <= '0; tzoQ <= '0; yTileQ <= '0;
    end else if (strobe.doSplit) begin
      nTxQ   <= (wBytesQ + tpMask) >> tpQ;
      nTyQ   <= (WORD_W'(heightQ) + thMask) >> thQ;
      txoQ   <= xBytesQ & tpMask;
      txQ    <= xBytesQ >> tpQ;
      tyoQ   <= WORD_W'(yQ) & thMask;
      tyQ    <= WORD_W'(yQ) >> thQ;
      tzoQ   <= WORD_W'(zQ) & tdMask;
      tzQ    <= WORD_W'(zQ) >> tdQ;
      yTileQ <= (thSize << YT_POS) | (thSize - (WORD_W'(yQ) & thMask));
    end
  end

  // stage 3: first products and in-tile offset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0; sliceQ <= '0; inTileQ <= '0;
    end else if (strobe.doMul) begin
      rowQ    <= tyQ * nTxQ;
      sliceQ  <= tzQ * nTyQ;
      inTileQ <= (tzoQ << (tpQ + thQ)) + (tyoQ << tpQ) + txoQ;
    end
  end

  // stage 4: slice product and total shift
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sliceFullQ <= '0; tsQ <= '0;
    end else if (strobe.doMul2) begin
      sliceFullQ <= sliceQ * nTxQ;
      tsQ        <= tpQ + thQ + tdQ;
    end
  end

  // stage 5: linear tile index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileIdxQ <= '0;
    end else if (strobe.doSum) begin
      tileIdxQ <= sliceFullQ + rowQ + txQ;
    end
  end

  // stage 6: result registers, written once per calculation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLow <= '0; cfgHigh <= '0; pitchWord <= '0;
      yTileWord <= '0; wideTile <= 1'b0;
    end else if (strobe.doFinal) begin
      addrLow   <= lowSum[WORD_W-1:0];
      cfgHigh   <= (WORD_W'(highNext) << HIGH_POS) | yzSize;
      pitchWord <= (nTxQ - ONE) << tsQ;
      yTileWord <= yTileQ;
      wideTile  <= wideQ;
    end
  end

endmodule

// File: rtl/tiled_addr_calc.sv
module tiled_addr_calc
  import tsac_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned HIGH_W  = 8,
  parameter int unsigned MODE_W  = 12,
  parameter int unsigned X_W     = 19,
  parameter int unsigned Y_W     = 13,
  parameter int unsigned Z_W     = 12,
  parameter int unsigned BPP_W   = 5,
  parameter int unsigned TH_BIAS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeWord,
  input  logic [X_W-1:0]    surfWidth,
  input  logic [Y_W-1:0]    surfHeight,
  input  logic [X_W-1:0]    xOff,
  input  logic [Y_W-1:0]    yOff,
  input  logic [Z_W-1:0]    zOff,
  input  logic [BPP_W-1:0]  bytesPerPixel,
  input  logic [WORD_W-1:0] baseLow,
  input  logic [HIGH_W-1:0] baseHigh,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] addrLow,
  output logic [WORD_W-1:0] cfgHigh,
  output logic [WORD_W-1:0] pitchWord,
  output logic [WORD_W-1:0] yTileWord,
  output logic              wideTile
);

  tsac_strobe_t strobe;

  tsac_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  tsac_datapath #(
    .WORD_W  (WORD_W),
    .HIGH_W  (HIGH_W),
    .MODE_W  (MODE_W),
    .X_W     (X_W),
    .Y_W     (Y_W),
    .Z_W     (Z_W),
    .BPP_W   (BPP_W),
    .TH_BIAS (TH_BIAS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .modeWord      (modeWord),
    .surfWidth     (surfWidth),
    .surfHeight    (surfHeight),
    .xOff          (xOff),
    .yOff          (yOff),
    .zOff          (zOff),
    .bytesPerPixel (bytesPerPixel),
    .baseLow       (baseLow),
    .baseHigh      (baseHigh),
    .addrLow       (addrLow),
    .cfgHigh       (cfgHigh),
    .pitchWord     (pitchWord),
    .yTileWord     (yTileWord),
    .wideTile      (wideTile)
  );

endmodule

// File: rtl/tiled_addr_calc_chk.sv
module tiled_addr_calc_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] addrLow,
  input logic [WORD_W-1:0] cfgHigh,
  input logic [WORD_W-1:0] pitchWord,
  input logic [WORD_W-1:0] yTileWord,
  input logic              wideTile
);

  localparam int unsigned LAT = tsac_pkg::STAGE_COUNT;

  logic [3:0] edgeCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                edgeCnt <= '0;
    else if (start && !busy)  edgeCnt <= '0;
    else if (busy)            edgeCnt <= edgeCnt + 4'd1;
  end

  // R8: done lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: accepted start makes the block busy
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R8: busy has dropped when done is raised
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: done arrives a fixed number of edges after acceptance
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (edgeCnt == 4'(LAT)));

  // R10: results hold outside the done cycle
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(addrLow) && $stable(cfgHigh) && $stable(pitchWord)
               && $stable(yTileWord) && $stable(wideTile)));

endmodule

bind tiled_addr_calc tiled_addr_calc_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tiled_addr_calc_bench.sv
`timescale 1ns/1ps
module tiled_addr_calc_bench;

  typedef struct packed {
    logic [11:0] mode;
    logic [18:0] w;
    logic [12:0] h;
    logic [18:0] x;
    logic [12:0] y;
    logic [11:0] z;
    logic [4:0]  bpp;
    logic [31:0] bl;
    logic [7:0]  bh;
  } stim_t;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] cfg;
    logic [31:0] pitch;
    logic [31:0] ytile;
    logic        wide;
  } res_t;

  localparam int NVEC = 6;
  localparam stim_t VECS [NVEC] = '{
    '{12'h00E, 19'd64,   13'd8,    19'd5,    13'd6,   12'd3,    5'd4,  32'h0000_1000, 8'h12},
    '{12'h215, 19'd300,  13'd100,  19'd77,   13'd19,  12'd9,    5'd3,  32'h0040_0000, 8'h01},
    '{12'h10E, 19'd1920, 13'd1080, 19'd1000, 13'd500, 12'd0,    5'd4,  32'h2000_0000, 8'h00},
    '{12'h33E, 19'd4096, 13'd512,  19'd4000, 13'd300, 12'd40,   5'd16, 32'hFFFF_F000, 8'hFF},
    '{12'h0F0, 19'd1,    13'd1,    19'd0,    13'd0,   12'd0,    5'd1,  32'h0000_0005, 8'h07},
    '{12'hF20, 19'd100,  13'd30,   19'd63,   13'd15,  12'd4095, 5'd2,  32'h0001_0000, 8'h3C}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [11:0] modeWord = '0;
  logic [18:0] surfWidth = '0, xOff = '0;
  logic [12:0] surfHeight = '0, yOff = '0;
  logic [11:0] zOff = '0;
  logic [4:0]  bytesPerPixel = '0;
  logic [31:0] baseLow = '0;
  logic [7:0]  baseHigh = '0;
  logic busy, done, wideTile;
  logic [31:0] addrLow, cfgHigh, pitchWord, yTileWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tiled_addr_calc u_tiled_addr_calc (
    .clk(clk), .rstN(rstN), .start(start), .modeWord(modeWord),
    .surfWidth(surfWidth), .surfHeight(surfHeight), .xOff(xOff),
    .yOff(yOff), .zOff(zOff), .bytesPerPixel(bytesPerPixel),
    .baseLow(baseLow), .baseHigh(baseHigh), .busy(busy), .done(done),
    .addrLow(addrLow), .cfgHigh(cfgHigh), .pitchWord(pitchWord),
    .yTileWord(yTileWord), .wideTile(wideTile)
  );

  // reference model written from the requirements
  function automatic res_t model(stim_t s);
    res_t r;
    logic [31:0] tp, th, td, xb, wb, ntx, nty, tx, txo, ty, tyo, tz, tzo;
    logic [31:0] inTile, idx, off, ts, hs;
    logic [32:0] sum;
    logic [7:0]  hi;
    tp  = (s.mode[3:0] == 4'hE) ? 32'd4 : 32'd6;
    th  = 32'(s.mode[7:4]) + 32'd2;
    td  = 32'(s.mode[11:8]);
    ts  = tp + th + td;
    hs  = 32'd1 << th;
    xb  = 32'(s.x) * 32'(s.bpp);
    wb  = 32'(s.w) * 32'(s.bpp);
    ntx = (wb + (32'd1 << tp) - 1) >> tp;
    nty = (32'(s.h) + hs - 1) >> th;
    txo = xb & ((32'd1 << tp) - 1);  tx = xb >> tp;
    tyo = 32'(s.y) & (hs - 1);       ty = 32'(s.y) >> th;
    tzo = 32'(s.z) & ((32'd1 << td) - 1); tz = 32'(s.z) >> td;
    inTile = (tzo << (tp + th)) + (tyo << tp) + txo;
    idx = tz * nty * ntx + ty * ntx + tx;
    off = (idx << ts) + inTile;
    sum = {1'b0, s.bl} + {1'b0, off};
    hi  = s.bh + 8'(sum[32]);
    r.addr  = sum[31:0];
    r.cfg   = (32'(hi) << 16) | ((hs >> 2) << td);
    r.pitch = (ntx - 1) << ts;
    r.ytile = (hs << 12) | (hs - tyo);
    r.wide  = (s.mode[3:0] != 4'hE);
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic chkRes(input string req, input res_t e);
    chk(req, "addrLow R3", addrLow, e.addr);
    chk(req, "cfgHigh R4/R5", cfgHigh, e.cfg);
    chk(req, "pitchWord R6", pitchWord, e.pitch);
    chk(req, "yTileWord R7", yTileWord, e.ytile);
    chk(req, "wideTile R2", 32'(wideTile), 32'(e.wide));
  endtask

  task automatic drive(input stim_t s);
    modeWord = s.mode; surfWidth = s.w; surfHeight = s.h; xOff = s.x;
    yOff = s.y; zOff = s.z; bytesPerPixel = s.bpp; baseLow = s.bl; baseHigh = s.bh;
  endtask

  // called at a negedge; returns at the next negedge with start low
  // and inputs scrambled to show they were latched (R9)
  task automatic startOp(input stim_t s);
    drive(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive(~s);
  endtask

  task automatic waitDone(inout int cyc);
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 timeout: actual no done expected done");
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    res_t e;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chkRes("R1", '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", 32'(done), 0);
    chk("R1", "addrLow after release", addrLow, 0);

    // table walk (R2..R7, R8 latency, R9 latching)
    for (int i = 0; i < NVEC; i++) begin
      startOp(VECS[i]);
      chk("R8", "busy after accept", 32'(busy), 1);
      cyc = 1;
      waitDone(cyc);
      chk("R8", "latency", cyc, 7);
      chk("R8", "busy at done", 32'(busy), 0);
      chkRes("R3", model(VECS[i]));
      @(negedge clk);
      chk("R8", "done single", 32'(done), 0);
    end

    // hand-worked vector 0 (R3..R7)
    chk("R2", "hand wide", 32'(1'b0), 32'(model(VECS[0]).wide));
    startOp(VECS[0]);
    cyc = 1; waitDone(cyc);
    chk("R3", "hand addrLow", addrLow, 32'h0000_2C64);
    chk("R5", "hand cfgHigh", cfgHigh, 32'h0012_0001);
    chk("R6", "hand pitch", pitchWord, 32'h0000_03C0);
    chk("R7", "hand ytile", yTileWord, 32'h0000_4002);
    chk("R2", "hand wide", 32'(wideTile), 0);
    // carry vector: high wraps from 0xFF to 0x00 (R4)
    startOp(VECS[3]);
    cyc = 1; waitDone(cyc);
    chk("R4", "wrapped high", 32'(cfgHigh[23:16]), 0);

    // R10: outputs hold while inputs change
    @(negedge clk);
    drive(VECS[1]);
    repeat (5) @(negedge clk);
    chkRes("R10", model(VECS[3]));

    // R9: start while busy is ignored
    startOp(VECS[2]);
    @(negedge clk);
    drive(VECS[5]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3; waitDone(cyc);
    chk("R9", "latency with extra start", cyc, 7);
    chkRes("R9", model(VECS[2]));
    begin
      int extra = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R9", "extra done pulses", extra, 0);
    end

    // R11: start in the done cycle
    startOp(VECS[1]);
    cyc = 1; waitDone(cyc);
    e = model(VECS[1]);
    chkRes("R11", e);
    drive(VECS[5]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy after back-to-back accept", 32'(busy), 1);
    repeat (3) @(negedge clk);
    chk("R10", "first result held", addrLow, e.addr);
    cyc = 4; waitDone(cyc);
    chk("R11", "second latency", cyc, 7);
    chkRes("R11", model(VECS[5]));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule